// File: doc/BRIEF.md
# Cache Block Refill Controller

This block sits on the memory side of a cache and answers a miss by fetching one four-word block. A single request carries a block address. The controller spends one cycle sending that address. It then waits out the memory access time and streams the four words back over a lane-per-word return port. A flag marks the final transfer, and the controller records how many cycles the miss took.

The memory organisation is picked at build time by the `ORG` parameter. Four organisations are available:

- `0`: a one-word memory on a one-word bus.
- `1`: a two-word memory on a two-word bus.
- `2`: a memory and bus as wide as the whole block.
- `3`: four one-word banks on a one-word bus. All four banks are accessed together, and their words are then sent one per clock.

Every organisation uses the same port list. Only the schedule of return transfers changes, so a cache can be paired with any of them without modification. The memory contents are a fixed function of the word address, which stands in for a read-only backing store.

Top module: `refill_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `rvalid` is 0, `rlast` is 0 and `miss_lat` is 0.
- R2: A request is taken only at a clock edge where `req` is 1 and `busy` is 0. A request raised while `busy` is 1 is ignored, and it changes neither the words returned nor their timing.
- R3: Cycle 1 is the cycle right after the edge that takes a request. `busy` is 1 from cycle 1 through the cycle of the final transfer and is 0 in the cycle after it. `rvalid` is 0 whenever `busy` is 0.
- R4: With `ORG`=0, one lane is valid per transfer. Lane i (word offset i) is valid in cycle 17+16*i, so the miss takes 65 cycles.
- R5: With `ORG`=1, lanes 0 and 1 are valid together in cycle 17, and lanes 2 and 3 are valid together in cycle 33.
- R6: With `ORG`=2, all four lanes are valid together in cycle 17.
- R7: With `ORG`=3, the bank holding a word is given by the two low bits of its word address, and bank i drives lane i. Lane i is valid alone in cycle 17+i, so the miss takes 20 cycles.
- R8: The word address of lane i is {block address, i}. While lane i is valid, its slice `rdata[32*i +: 32]` equals (wa * 0x9E3779B1) ^ 0x5A5A0F0F, truncated to 32 bits, where wa is that word address zero-extended to 32 bits. A slice whose lane is not valid reads 0.
- R9: Each lane is valid in exactly one cycle per request. `rlast` is 1 only in the cycle that carries lane 3.
- R10: From the cycle after the final transfer, `miss_lat` holds that transfer's cycle number, counting the address cycle as 1. This gives 65, 33, 17 or 20 for `ORG` 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Block read request |
| blk_addr | input | AW | Block address (word address divided by four) |
| busy | output | 1 | A block is in flight; new requests are refused |
| rvalid | output | 4 | Per-lane valid for the current transfer |
| rlast | output | 1 | This transfer completes the block |
| rdata | output | 4*DW | Four word lanes, lane i in bits DW*i upward |
| miss_lat | output | LATW | Cycle count of the last completed miss |

## Verification
Several properties hold on every cycle and are checked by the assertions: returns never appear while the controller is idle, a taken request raises `busy` on the next cycle, each transfer carries exactly the lane count of the organisation, `rlast` coincides with lane 3, and the recorded latency matches the organisation's total. The exact cycle of each lane and the word values themselves can only be shown by the bench's scenarios. So can the fact that requests raised mid-block leave the result untouched. The bench builds all four organisations side by side and compares them against the same cycle schedule.

// File: rtl/refill_ctrl.sv
module refill_ctrl #(
  parameter int ORG     = 3,
  parameter int AW      = 10,
  parameter int DW      = 32,
  parameter int ACC_CYC = 15,
  parameter int LATW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [AW-1:0]     blk_addr,
  output logic              busy,
  output logic [3:0]        rvalid,
  output logic              rlast,
  output logic [4*DW-1:0]   rdata,
  output logic [LATW-1:0]   miss_lat
);
  localparam int WORDS  = 4;
  localparam int LANES  = (ORG == 1) ? 2 : (ORG == 2) ? 4 : 1;
  localparam int GROUPS = WORDS / LANES;
  localparam bit BANKED = (ORG == 3);
  localparam int TOTAL  = BANKED ? 1 + ACC_CYC + WORDS : 1 + GROUPS * (ACC_CYC + 1);
  localparam int WW     = $clog2(ACC_CYC) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_ACC, S_XFER} st_t;

  st_t             state;
  logic [WW-1:0]   wcnt;
  logic [1:0]      grp;
  logic [AW-1:0]   blk_q;
  logic [LATW-1:0] lat_cnt;

  wire xfer     = (state == S_XFER);
  wire grp_last = (grp == 2'(GROUPS - 1));

  function automatic logic [DW-1:0] word_val(input logic [AW+1:0] wa);
    logic [31:0] p;
    p = 32'(wa) * 32'h9E3779B1;
    return DW'(p ^ 32'h5A5A0F0F);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wcnt     <= '0;
      grp      <= '0;
      blk_q    <= '0;
      lat_cnt  <= '0;
      miss_lat <= '0;
    end else begin
      case (state)
        S_IDLE: if (req) begin
          state   <= S_ADDR;
          blk_q   <= blk_addr;
          lat_cnt <= LATW'(1);
        end
        S_ADDR: begin
          state   <= S_ACC;
          wcnt    <= WW'(ACC_CYC - 1);
          grp     <= '0;
          lat_cnt <= lat_cnt + 1'b1;
        end
        S_ACC: begin
          lat_cnt <= lat_cnt + 1'b1;
          if (wcnt == '0) state <= S_XFER;
          else            wcnt  <= wcnt - 1'b1;
        end
        S_XFER: begin
          lat_cnt <= lat_cnt + 1'b1;
          if (grp_last) begin
            state    <= S_IDLE;
            miss_lat <= lat_cnt;
          end else begin
            grp <= grp + 1'b1;
            if (!BANKED) begin
              state <= S_ACC;
              wcnt  <= WW'(ACC_CYC - 1);
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy  = (state != S_IDLE);
  assign rlast = xfer && grp_last;

  // lane i is word offset i; when banked, bank i is the one whose word
  // addresses end in i, so it drives lane i
  for (genvar i = 0; i < WORDS; i++) begin : g_lane
    assign rvalid[i] = xfer && (grp == 2'(i / LANES));
    assign rdata[DW*i +: DW] = rvalid[i] ? word_val({blk_q, 2'(i)}) : '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rvalid == 4'b0)); // R3
  AST_TAKE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy); // R2
  AST_XFER_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid != 4'b0) |-> ($countones(rvalid) == LANES)); // R4
  AST_LAST_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    rlast |-> rvalid[3]); // R9
  AST_LAT_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    rlast |=> (miss_lat == LATW'(TOTAL))); // R10
endmodule

// File: tb/refill_ctrl_test.sv
module refill_ctrl_test;
  localparam int PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic req = 0;
  logic [AW-1:0] blk_in = '0;

  logic [3:0]            busy_v;
  logic [3:0][3:0]       rv_v;
  logic [3:0]            rl_v;
  logic [3:0][4*DW-1:0]  rd_v;
  logic [3:0][7:0]       lat_v;

  int total_checks = 0;
  int bad_checks = 0;

  always #(PERIOD/2) clk = ~clk;

  refill_ctrl #(.ORG(0)) uut_narrow (.clk(clk), .rst_n(rst_n), .req(req), .blk_addr(blk_in),
    .busy(busy_v[0]), .rvalid(rv_v[0]), .rlast(rl_v[0]), .rdata(rd_v[0]), .miss_lat(lat_v[0]));
  refill_ctrl #(.ORG(1)) uut_pair (.clk(clk), .rst_n(rst_n), .req(req), .blk_addr(blk_in),
    .busy(busy_v[1]), .rvalid(rv_v[1]), .rlast(rl_v[1]), .rdata(rd_v[1]), .miss_lat(lat_v[1]));
  refill_ctrl #(.ORG(2)) uut_wide (.clk(clk), .rst_n(rst_n), .req(req), .blk_addr(blk_in),
    .busy(busy_v[2]), .rvalid(rv_v[2]), .rlast(rl_v[2]), .rdata(rd_v[2]), .miss_lat(lat_v[2]));
  refill_ctrl #(.ORG(3)) uut (.clk(clk), .rst_n(rst_n), .req(req), .blk_addr(blk_in),
    .busy(busy_v[3]), .rvalid(rv_v[3]), .rlast(rl_v[3]), .rdata(rd_v[3]), .miss_lat(lat_v[3]));

  function automatic int total_of(input int o);
    case (o)
      0: return 65;
      1: return 33;
      2: return 17;
      default: return 20;
    endcase
  endfunction

  function automatic int lane_cyc(input int o, input int i);
    case (o)
      0: return 17 + 16 * i;
      1: return 17 + 16 * (i / 2);
      2: return 17;
      default: return 17 + i;
    endcase
  endfunction

  function automatic logic [31:0] exp_word(input logic [AW-1:0] blk, input int i);
    logic [31:0] wa;
    wa = {20'b0, blk, 2'(i)};
    return (wa * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    for (int o = 0; o < 4; o++) begin
      check(busy_v[o] == 1'b0 && rv_v[o] == 4'b0 && rl_v[o] == 1'b0,
            "R1 idle outputs after reset", {busy_v[o], rv_v[o], rl_v[o]}, 0);
      check(lat_v[o] == 8'd0, "R1 miss_lat after reset", lat_v[o], 0);
    end
  endtask

  task automatic t_block(input logic [AW-1:0] blk, input bit poke);
    int seen [4][4];
    int hits [4][4];
    int lastc [4];
    int busy_err [4];
    for (int o = 0; o < 4; o++) begin
      lastc[o] = 0;
      busy_err[o] = 0;
      for (int i = 0; i < 4; i++) begin
        seen[o][i] = 0;
        hits[o][i] = 0;
      end
    end
    @(negedge clk);
    req = 1;
    blk_in = blk;
    @(negedge clk);
    req = 0;
    for (int n = 1; n <= 70; n++) begin
      for (int o = 0; o < 4; o++) begin
        if (busy_v[o] != (n <= total_of(o))) busy_err[o]++;
        if (rl_v[o]) lastc[o] = n;
        for (int i = 0; i < 4; i++) begin
          if (rv_v[o][i]) begin
            hits[o][i]++;
            seen[o][i] = n;
            check(rd_v[o][32*i +: 32] == exp_word(blk, i), "R8 lane data",
                  rd_v[o][32*i +: 32], exp_word(blk, i));
          end else if (rd_v[o][32*i +: 32] != 32'b0) begin
            check(1'b0, "R8 idle lane not zero", rd_v[o][32*i +: 32], 0);
          end
        end
      end
      // R2: requests raised mid-block with another address must be ignored
      req = poke && (n >= 4) && (n < 10);
      blk_in = poke ? (blk ^ 10'h155) : blk;
      @(negedge clk);
    end
    req = 0;
    for (int o = 0; o < 4; o++) begin
      for (int i = 0; i < 4; i++)
        check(hits[o][i] == 1 && seen[o][i] == lane_cyc(o, i),
              o == 0 ? "R4 narrow lane cycle" : o == 1 ? "R5 pair lane cycle" :
              o == 2 ? "R6 wide lane cycle" : "R7 banked lane cycle",
              seen[o][i] * 100 + hits[o][i], lane_cyc(o, i) * 100 + 1);
      check(lastc[o] == total_of(o), "R9 rlast cycle", lastc[o], total_of(o));
      check(lat_v[o] == 8'(total_of(o)), "R10 miss_lat", lat_v[o], total_of(o));
      check(busy_err[o] == 0, poke ? "R2 busy window with pokes" : "R3 busy window",
            busy_err[o], 0);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    bad_checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_block(10'h000, 1'b0);
    t_block(10'h3FF, 1'b0);
    t_block(10'h07B, 1'b1);
    t_block(10'h2A6, 1'b0);
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end
endmodule